// File: doc/BRIEF.md
# Digital Dimming Pattern Generator

This block produces the on/off drive for one LED channel from a 13-bit brightness word. The length of one dimming period is set by a 3-bit resolution select, from 64 ticks (6 bits) up to 8192 ticks (13 bits). At lower resolutions only the most significant bits of the word count. A mode input picks between two waveforms. The first is a conventional single pulse at the start of each period. The second is bit angle modulation, where each code bit owns a time slot whose length is its binary weight.

The period advances on a tick from a shared period clock, not on every system clock. The word, the mode and the resolution are captured in a shadow copy at each period boundary, so a change arriving mid-period never produces a truncated or mixed period. An enable input starts the generator from the top of a period. A fault input blanks the output in the same cycle it is raised, while the period keeps running underneath.

Top module: `dim_pattern_gen`

## Requirements
- R1: While `rst` is high, and until the first period boundary after it, the active configuration is PWM mode, resolution select 0 and code 0, so `dim_o` stays low for the first 64 ticks after reset. The position is 0 when reset is released.
- R2: Resolution select value s (0..7) gives N = 6 + s bits. The period is 2^N ticks and the effective code is `code_i[12:13-N]`, meaning the code shifted right by 7 - s.
- R3: In PWM mode (`bam_sel_i` = 0), `dim_o` is high at position p exactly when p is less than the effective code. Code 0 is always off, and an all-ones code is on for 2^N - 1 of the 2^N positions.
- R4: In BAM mode (`bam_sel_i` = 1), bit k of the effective code drives `dim_o` for positions 2^k - 1 through 2^(k+1) - 2. The slots run in ascending bit order, and the final position 2^N - 1 is always off.
- R5: The mode input selects between the R3 and R4 waveforms: 0 selects PWM and 1 selects BAM.
- R6: The position advances by one only on a clock edge where `tick_i` is high. Without a tick, the position and `dim_o` hold their values.
- R7: Changes on `code_i`, `res_sel_i` and `bam_sel_i` take effect only at the tick that ends a period, or while `enable_i` is low. The period in progress completes with its old settings.
- R8: While `enable_i` is low, `dim_o` is low and the position is held at 0, even when ticks arrive. The first period after enable rises starts at position 0 with the inputs present while the block was disabled.
- R9: While `fault_i` is high, `dim_o` is low in that same cycle. The position keeps advancing, so the pattern resumes at the correct position when the fault clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle strobe that advances the period position |
| enable_i | input | 1 | Runs the generator; low forces the output off and rewinds the position |
| fault_i | input | 1 | Channel fault; forces the output off immediately |
| code_i | input | 13 | Brightness word, MSB-aligned |
| res_sel_i | input | 3 | Resolution select; N = 6 + value |
| bam_sel_i | input | 1 | 0 = single-pulse PWM, 1 = bit angle modulation |
| dim_o | output | 1 | Dimming drive for the channel |

## Verification
The hardest situation to reach from the ports is a settings change that lands inside a period at a high resolution, followed by the reload at the period boundary under the old length. The bench also has to see a long BAM slot for the top bit while ticks are irregular. To get there, the stimulus rewrites the code, mode and resolution at random points mid-period. It inserts random idle cycles between ticks and runs full 13-bit periods in both modes. A reference model in the bench tracks the position and the shadow configuration, and it swaps in new settings only at the wrap tick. Fault and enable are toggled mid-period to show that blanking does not disturb the position.

// File: rtl/dim_pkg.sv
package dim_pkg;

    // Width of the brightness word and of the resolution select.
    parameter int CODE_W = 13;
    parameter int SEL_W  = 3;

    // Lowest resolution reachable: the select covers CODE_W down to this.
    localparam int MIN_RES = CODE_W - (2 ** SEL_W) + 1;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [SEL_W-1:0]  sel_t;

    typedef enum logic {
        MODE_PWM = 1'b0,
        MODE_BAM = 1'b1
    } mode_e;

    typedef struct packed {
        code_t code;
        sel_t  res_sel;
        mode_e mode;
    } cfg_t;

    // Bits dropped from the word equal (all-ones select) - select = ~select.
    function automatic code_t eff_code(code_t code, sel_t sel);
        return code >> (~sel);
    endfunction

    // Final position of a period: 2^N - 1.
    function automatic code_t last_pos(sel_t sel);
        return code_t'('1) >> (~sel);
    endfunction

endpackage

// File: rtl/dim_cfg_shadow.sv
module dim_cfg_shadow
    import dim_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  cfg_t cfg_d,
    output cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= cfg_t'('0);
        end else if (load) begin
            cfg_q <= cfg_d;
        end
    end

endmodule

// File: rtl/dim_period_counter.sv
module dim_period_counter
    import dim_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    input  logic  tick,
    input  code_t last,
    output code_t pos,
    output logic  wrap
);

    logic at_last;

    assign at_last = (pos == last);
    assign wrap    = run & tick & at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (!run) begin
            pos <= '0;
        end else if (tick) begin
            pos <= at_last ? '0 : pos + code_t'(1);
        end
    end

endmodule

// File: rtl/dim_pattern_decode.sv
module dim_pattern_decode
    import dim_pkg::*;
(
    input  code_t pos,
    input  cfg_t  cfg,
    output logic  pat
);

    code_t             eff;
    code_t             last;
    logic [CODE_W:0]   pos_inc;
    logic [CODE_W-1:0] in_slot;
    logic              pwm_pat;
    logic              bam_pat;

    assign eff     = eff_code(cfg.code, cfg.res_sel);
    assign last    = last_pos(cfg.res_sel);
    assign pos_inc = {1'b0, pos} + (CODE_W+1)'(1);

    // Slot k covers positions whose successor has its leading one at bit k;
    // a slot exists only below the active resolution.
    for (genvar k = 0; k < CODE_W; k++) begin : g_slot
        assign in_slot[k] = last[k] & pos_inc[k] & ~(|pos_inc[CODE_W:k+1]);
    end

    assign bam_pat = |(in_slot & eff);
    assign pwm_pat = (pos < eff);
    assign pat     = (cfg.mode == MODE_BAM) ? bam_pat : pwm_pat;

endmodule

// File: rtl/dim_pattern_gen.sv
module dim_pattern_gen
    import dim_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick_i,
    input  logic                    enable_i,
    input  logic                    fault_i,
    input  logic [dim_pkg::CODE_W-1:0] code_i,
    input  logic [dim_pkg::SEL_W-1:0]  res_sel_i,
    input  logic                    bam_sel_i,
    output logic                    dim_o
);

    cfg_t  cfg_d;
    cfg_t  cfg_q;
    code_t pos_q;
    logic  wrap;
    logic  pat;

    assign cfg_d = '{code: code_i, res_sel: res_sel_i,
                     mode: (bam_sel_i ? MODE_BAM : MODE_PWM)};

    dim_cfg_shadow u_shadow (
        .clk   (clk),
        .rst   (rst),
        .load  (~enable_i | wrap),
        .cfg_d (cfg_d),
        .cfg_q (cfg_q)
    );

    dim_period_counter u_count (
        .clk  (clk),
        .rst  (rst),
        .run  (enable_i),
        .tick (tick_i),
        .last (last_pos(cfg_q.res_sel)),
        .pos  (pos_q),
        .wrap (wrap)
    );

    dim_pattern_decode u_decode (
        .pos (pos_q),
        .cfg (cfg_q),
        .pat (pat)
    );

    assign dim_o = enable_i & ~fault_i & pat;

endmodule

// File: rtl/dim_pattern_checker.sv
module dim_pattern_checker
    import dim_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  enable_i,
    input logic  tick_i,
    input logic  fault_i,
    input logic  dim_o,
    input code_t pos,
    input cfg_t  cfg,
    input logic  wrap
);

    p_fault_off_r9: assert property (@(posedge clk) disable iff (rst)
        fault_i |-> !dim_o);

    p_disabled_rewind_r8: assert property (@(posedge clk) disable iff (rst)
        !enable_i |=> (pos == '0));

    p_hold_no_tick_r6: assert property (@(posedge clk) disable iff (rst)
        (enable_i && !tick_i) |=> (pos == $past(pos)));

    p_step_on_tick_r6: assert property (@(posedge clk) disable iff (rst)
        (enable_i && tick_i && !wrap) |=> (pos == $past(pos) + code_t'(1)));

    p_pos_in_range_r2: assert property (@(posedge clk) disable iff (rst)
        pos <= last_pos(cfg.res_sel));

    p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        (enable_i && !wrap) |=> $stable(cfg));

    p_zero_code_off_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == MODE_PWM && eff_code(cfg.code, cfg.res_sel) == '0) |-> !dim_o);

    p_bam_tail_off_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == MODE_BAM && pos == last_pos(cfg.res_sel)) |-> !dim_o);

endmodule

bind dim_pattern_gen dim_pattern_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .enable_i (enable_i),
    .tick_i   (tick_i),
    .fault_i  (fault_i),
    .dim_o    (dim_o),
    .pos      (pos_q),
    .cfg      (cfg_q),
    .wrap     (wrap)
);

// File: tb/sim_dim_pattern_gen.sv
module sim_dim_pattern_gen;
    import dim_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_i = 1'b0;
    logic        enable_i = 1'b1;
    logic        fault_i = 1'b0;
    logic [CODE_W-1:0] code_i = '1;
    logic [SEL_W-1:0]  res_sel_i = '0;
    logic        bam_sel_i = 1'b0;
    logic        dim_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state.
    logic [CODE_W-1:0] a_code;
    logic [SEL_W-1:0]  a_sel;
    bit                a_bam;
    int                pos;

    always #(CLK_PERIOD/2) clk = ~clk;

    dim_pattern_gen u0 (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick_i),
        .enable_i  (enable_i),
        .fault_i   (fault_i),
        .code_i    (code_i),
        .res_sel_i (res_sel_i),
        .bam_sel_i (bam_sel_i),
        .dim_o     (dim_o)
    );

    function automatic int period_of(logic [SEL_W-1:0] s);
        return 1 << (MIN_RES + int'(s));
    endfunction

    function automatic bit exp_bit(logic [CODE_W-1:0] code, logic [SEL_W-1:0] s,
                                   bit bam, int p);
        int n = MIN_RES + int'(s);
        int e = int'(code) >> (CODE_W - n);
        int succ = p + 1;
        int lead = 0;
        if (!bam) return (p < e);
        for (int b = 0; b <= CODE_W; b++) if (((succ >> b) & 1) == 1) lead = b;
        if (lead >= n) return 1'b0;
        return ((e >> lead) & 1) == 1;
    endfunction

    task automatic check_val(string req, bit got, bit exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s pos %0d actual %0b expected %0b", req, pos, got, exp);
        end
    endtask

    task automatic chk_now(string req);
        bit e = (enable_i && !fault_i) ? exp_bit(a_code, a_sel, a_bam, pos) : 1'b0;
        check_val(req, dim_o, e);
    endtask

    // Called just after a falling edge; leaves just after a falling edge.
    task automatic run(int count, string req, bit gaps);
        for (int j = 0; j < count; j++) begin
            #1;
            chk_now(req);
            if (gaps && $urandom_range(0, 3) == 0) begin
                @(negedge clk);
                #1;
                chk_now("R6");
            end
            tick_i = 1'b1;
            @(negedge clk);
            tick_i = 1'b0;
            if (pos == period_of(a_sel) - 1) begin
                pos    = 0;
                a_code = code_i;
                a_sel  = res_sel_i;
                a_bam  = bam_sel_i;
            end else begin
                pos++;
            end
        end
    endtask

    task automatic drive_cfg(logic [CODE_W-1:0] c, logic [SEL_W-1:0] s, bit b);
        code_i    = c;
        res_sel_i = s;
        bam_sel_i = b;
    endtask

    // Disable for a few cycles with ticks present, then restart.
    task automatic restart();
        enable_i = 1'b0;
        tick_i   = 1'b1;
        for (int j = 0; j < 3; j++) begin
            #1;
            check_val("R8", dim_o, 1'b0);
            @(negedge clk);
        end
        tick_i   = 1'b0;
        enable_i = 1'b1;
        pos    = 0;
        a_code = code_i;
        a_sel  = res_sel_i;
        a_bam  = bam_sel_i;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int rem;
        void'($urandom(32'd1234));

        // R1: output low throughout reset even with enable and a full code.
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            #1;
            check_val("R1", dim_o, 1'b0);
        end
        @(negedge clk);
        rst    = 1'b0;
        a_code = '0;
        a_sel  = '0;
        a_bam  = 1'b0;
        pos    = 0;
        // R1: cleared configuration governs the first 64-tick period.
        run(64, "R1", 1'b0);
        // R3: all-ones code at 6 bits, on for 63 of 64.
        run(64, "R3", 1'b0);

        // R3: code 0 never drives at 8 bits.
        drive_cfg(13'h0000, 3'd2, 1'b0);
        restart();
        run(period_of(3'd2), "R3", 1'b1);

        // R4/R5: BAM at 7 bits, alternating bits.
        drive_cfg(13'b1010101_000000, 3'd1, 1'b1);
        restart();
        run(period_of(3'd1), "R4", 1'b0);
        // R4: single top bit at 7 bits.
        drive_cfg(13'b1000000_000000, 3'd1, 1'b1);
        restart();
        run(period_of(3'd1), "R4", 1'b1);

        // R2: low bits ignored at 6 bits; PWM width from top 6 bits only.
        drive_cfg(13'b0001011_111111, 3'd0, 1'b0);
        restart();
        run(period_of(3'd0), "R2", 1'b0);

        // R7: mid-period change; old period completes, new one takes over.
        drive_cfg(13'h0A00, 3'd3, 1'b0);
        restart();
        run(period_of(3'd3) / 2, "R7", 1'b1);
        drive_cfg(13'h1380, 3'd1, 1'b1);
        run(period_of(3'd3) / 2 + period_of(3'd1), "R7", 1'b1);

        // R9: fault blanks mid-period; position keeps moving.
        drive_cfg(13'h1F00, 3'd2, 1'b0);
        restart();
        run(40, "R9", 1'b0);
        fault_i = 1'b1;
        run(80, "R9", 1'b1);
        fault_i = 1'b0;
        run(period_of(3'd2) - 120, "R9", 1'b0);

        // R8: disable mid-period rewinds to position 0.
        drive_cfg(13'h0C00, 3'd1, 1'b0);
        restart();
        run(50, "R8", 1'b0);
        drive_cfg(13'h1200, 3'd1, 1'b1);
        restart();
        run(period_of(3'd1), "R8", 1'b0);

        // R2: full 13-bit periods in both modes.
        drive_cfg(13'h1234, 3'd7, 1'b0);
        restart();
        run(period_of(3'd7), "R2", 1'b0);
        drive_cfg(13'h1555, 3'd7, 1'b1);
        restart();
        run(period_of(3'd7), "R5", 1'b0);

        // Random settings, changed mid-period, with idle gaps (R6, R7).
        for (int it = 0; it < 16; it++) begin
            drive_cfg(13'($urandom), 3'($urandom_range(0, 4)), 1'($urandom_range(0, 1)));
            rem = period_of(a_sel) - pos;
            run(rem, "R7", 1'b1);
            run($urandom_range(1, period_of(a_sel)), "R6", 1'b1);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule